// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Lookup

This block is the lookup path of a set-associative data cache whose set is chosen only from address bits below the page boundary. Those bits are the same before and after translation. The tag and data arrays can therefore be read from the virtual address while the translation buffer works in parallel. In the same cycle, the stored physical tags are compared with the translated physical page number. Lines that are aliases of one another (different virtual pages mapped to the same physical page) always fall in the same set. They can never sit in two places at once.

With the default parameters, the virtual address is 24 bits and pages are 4 KiB, so 12 bits are untranslated. Lines are 64 bytes, which leaves 6 bits for the set and gives 64 sets. The 64 KiB capacity comes from 16 ways, not from more sets. A lookup presents the address, the translated page number and its valid flag together. One cycle later the block returns registered hit, way and read-word results. Lines are written through a refill port. Each refill replaces the way named by a round-robin pointer kept per set.

Top module: `vipt_cache_lookup`

## Requirements
- R1: After reset, `rsp_valid` and `rsp_hit` are 0 and every line is invalid, so the first lookup of any address misses.
- R2: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` = 1, and 0 otherwise.
- R3: The set is `req_vaddr[11:6]` (`refill_index` on refill). `req_vaddr[23:12]` has no influence, so virtual aliases with equal set bits and the same physical page hit the same line.
- R4: A way matches only when it is valid and its stored tag equals `tlb_ppn`. Virtual page bits that equal a stored tag do not make a hit.
- R5: When `tlb_valid` is 0 the lookup reports a miss, whatever the arrays hold.
- R6: On a hit, `rsp_data` is the 32-bit word `req_vaddr[5:2]` of the line. Word k occupies bits [32k+31:32k] of `refill_line`.
- R7: Refills into one set use ways 0, 1, …, 15, 0, … in that order from reset. `rsp_way` is the binary index of the hit way.
- R8: If more than one valid way of the set matches `tlb_ppn`, the lookup reports a miss.
- R9: When `rsp_hit` is 0, `rsp_way` and `rsp_data` are 0.
- R10: A lookup in the same cycle as a refill sees the contents from before that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 24 | Virtual byte address of the lookup |
| tlb_ppn | input | 12 | Translated physical page number, same cycle |
| tlb_valid | input | 1 | Translation is valid |
| refill_valid | input | 1 | Write one line into the cache |
| refill_index | input | 6 | Set to refill |
| refill_ppn | input | 12 | Physical tag of the refilled line |
| refill_line | input | 512 | Line contents, word 0 in the low bits |
| rsp_valid | output | 1 | Result of last cycle's lookup is present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 4 | Hit way index |
| rsp_data | output | 32 | Selected word of the hit line |

## Verification
The bench builds the block with its default parameters: 24-bit addresses, 12 untranslated bits, 64-byte lines, 16 ways and 32-bit words. This is the full 64-set by 16-way geometry, so a single set can be filled past its last way and the round-robin wrap can be seen. Aliases differing in every virtual page bit are within reach, as are duplicate tags in one set. Random traffic is confined to a few sets with a small pool of page numbers, so that hits, replacements and duplicate matches occur often.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
   // Binary index of the single set bit of a one-hot vector (0 when empty).
   function automatic int unsigned onehot_index(input logic [63:0] vec);
      int unsigned idx;
      idx = 0;
      for (int i = 0; i < 64; i++) begin
         if (vec[i]) idx = idx | i;
      end
      return idx;
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/vipt_way_bank.sv
// One way of the cache: valid bits, physical tags and line storage, read
// asynchronously by set index and written on refill.
module vipt_way_bank #(
   parameter int unsigned SETS   = 64,
   parameter int unsigned IDX_W  = 6,
   parameter int unsigned TAG_W  = 12,
   parameter int unsigned LINE_W = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [LINE_W-1:0] wr_line,
   output logic              rd_vld,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [LINE_W-1:0] rd_line
);
   logic [SETS-1:0]   vld_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [LINE_W-1:0] line_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         line_q[wr_idx] <= wr_line;
      end
   end

   assign rd_vld  = vld_q[rd_idx];
   assign rd_tag  = tag_q[rd_idx];
   assign rd_line = line_q[rd_idx];
endmodule

// File: rtl/vipt_hit_select.sv
// Physical tag compare across all ways; a hit needs a valid translation and
// exactly one matching way. Outputs are zero on a miss.
module vipt_hit_select
   import vipt_pkg::*;
#(
   parameter int unsigned WAYS   = 16,
   parameter int unsigned WAY_W  = 4,
   parameter int unsigned TAG_W  = 12,
   parameter int unsigned LINE_W = 512
) (
   input  logic [WAYS-1:0]             way_vld,
   input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
   input  logic [WAYS-1:0][LINE_W-1:0] way_line,
   input  logic [TAG_W-1:0]            ppn,
   input  logic                        ppn_ok,
   output logic                        hit,
   output logic [WAY_W-1:0]            hit_way,
   output logic [LINE_W-1:0]           hit_line
);
   logic [WAYS-1:0] match;
   logic [WAYS-1:0] sel;
   logic            single;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = way_vld[w] && (way_tag[w] == ppn);
   end

   assign single = (match != '0) && ((match & (match - 1'b1)) == '0);
   assign hit    = ppn_ok && single;
   assign sel    = hit ? match : '0;

   always_comb begin
      hit_line = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (sel[w]) hit_line = hit_line | way_line[w];
      end
   end

   assign hit_way = WAY_W'(onehot_index(64'(sel)));
endmodule

// File: rtl/vipt_victim_rr.sv
// Per-set round-robin replacement pointer, advanced on each refill.
module vipt_victim_rr
   import vipt_pkg::*;
#(
   parameter int unsigned SETS  = 64,
   parameter int unsigned IDX_W = 6,
   parameter int unsigned WAYS  = 16,
   parameter int unsigned WAY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [IDX_W-1:0] adv_idx,
   output logic [WAY_W-1:0] victim
);
   logic [WAY_W-1:0] ptr_q [SETS];
   logic [WAY_W-1:0] ptr_nxt;

   assign victim = ptr_q[adv_idx];

   if (is_pow2(WAYS)) begin : g_wrap_free
      assign ptr_nxt = victim + 1'b1;
   end else begin : g_wrap_cmp
      assign ptr_nxt = (victim == WAY_W'(WAYS - 1)) ? '0 : victim + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
      end else if (adv) begin
         ptr_q[adv_idx] <= ptr_nxt;
      end
   end
endmodule

// File: rtl/vipt_cache_lookup.sv
// Top of the lookup path: set chosen from untranslated bits, physical tag
// compare against the translated page number, registered one-cycle result.
module vipt_cache_lookup
   import vipt_pkg::*;
#(
   parameter int unsigned VA_W       = 24,
   parameter int unsigned PAGE_OFF_W = 12,
   parameter int unsigned PPN_W      = 12,
   parameter int unsigned LINE_BYTES = 64,
   parameter int unsigned WAYS       = 16,
   parameter int unsigned DATA_W     = 32,
   localparam int unsigned LINE_W     = LINE_BYTES * 8,
   localparam int unsigned BLK_OFF_W  = $clog2(LINE_BYTES),
   localparam int unsigned BYTE_OFF_W = $clog2(DATA_W / 8),
   localparam int unsigned IDX_W      = PAGE_OFF_W - BLK_OFF_W,
   localparam int unsigned SETS       = 1 << IDX_W,
   localparam int unsigned WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int unsigned WORDS      = LINE_W / DATA_W,
   localparam int unsigned WSEL_W     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic [PPN_W-1:0]  tlb_ppn,
   input  logic              tlb_valid,
   input  logic              refill_valid,
   input  logic [IDX_W-1:0]  refill_index,
   input  logic [PPN_W-1:0]  refill_ppn,
   input  logic [LINE_W-1:0] refill_line,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [WAY_W-1:0]  rsp_way,
   output logic [DATA_W-1:0] rsp_data
);
   // Elaboration-time parameter checks
   if (PAGE_OFF_W <= BLK_OFF_W) begin : g_bad_split
      $error("page offset must exceed the line offset");
   end
   if (VA_W <= PAGE_OFF_W) begin : g_bad_va
      $error("virtual address must be wider than the page offset");
   end
   if (!is_pow2(LINE_BYTES) || !is_pow2(DATA_W / 8) || DATA_W < 8) begin : g_bad_line
      $error("line and word sizes must be powers of two bytes");
   end
   if (DATA_W > LINE_W || BYTE_OFF_W == 0) begin : g_bad_word
      $error("word must fit in a line and be wider than a byte");
   end
   if (WAYS < 2 || WAYS > 64) begin : g_bad_ways
      $error("WAYS must lie in 2..64");
   end

   logic [IDX_W-1:0]  lk_idx;
   logic [WSEL_W-1:0] lk_word;
   logic              unused_vaddr_bits;

   assign lk_idx            = req_vaddr[PAGE_OFF_W-1:BLK_OFF_W];
   assign unused_vaddr_bits = ^{req_vaddr[VA_W-1:PAGE_OFF_W], req_vaddr[BYTE_OFF_W-1:0]};

   if (WORDS > 1) begin : g_wsel
      assign lk_word = req_vaddr[BLK_OFF_W-1:BYTE_OFF_W];
   end else begin : g_wsel_none
      assign lk_word = '0;
   end

   // Replacement
   logic [WAY_W-1:0] victim;

   vipt_victim_rr #(
      .SETS (SETS), .IDX_W(IDX_W), .WAYS(WAYS), .WAY_W(WAY_W)
   ) victim_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (refill_valid),
      .adv_idx(refill_index),
      .victim (victim)
   );

   // Way storage
   logic [WAYS-1:0]             way_vld;
   logic [WAYS-1:0][PPN_W-1:0]  way_tag;
   logic [WAYS-1:0][LINE_W-1:0] way_line;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic wr_this;
      assign wr_this = refill_valid && (victim == WAY_W'(w));

      vipt_way_bank #(
         .SETS(SETS), .IDX_W(IDX_W), .TAG_W(PPN_W), .LINE_W(LINE_W)
      ) bank_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .rd_idx (lk_idx),
         .wr_en  (wr_this),
         .wr_idx (refill_index),
         .wr_tag (refill_ppn),
         .wr_line(refill_line),
         .rd_vld (way_vld[w]),
         .rd_tag (way_tag[w]),
         .rd_line(way_line[w])
      );
   end

   // Tag compare and way select
   logic              hit_c;
   logic [WAY_W-1:0]  hit_way_c;
   logic [LINE_W-1:0] hit_line_c;

   vipt_hit_select #(
      .WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(PPN_W), .LINE_W(LINE_W)
   ) hsel_i (
      .way_vld (way_vld),
      .way_tag (way_tag),
      .way_line(way_line),
      .ppn     (tlb_ppn),
      .ppn_ok  (tlb_valid),
      .hit     (hit_c),
      .hit_way (hit_way_c),
      .hit_line(hit_line_c)
   );

   // Word select within the line
   logic [DATA_W-1:0] word_c;

   if (WORDS > 1) begin : g_word_mux
      logic [WORDS-1:0][DATA_W-1:0] words;
      assign words  = hit_line_c;
      assign word_c = words[lk_word];
   end else begin : g_word_whole
      logic unused_wsel;
      assign unused_wsel = ^lk_word;
      assign word_c      = hit_line_c[DATA_W-1:0];
   end

   // Registered result
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_way   <= '0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid && hit_c;
         rsp_way   <= (req_valid && hit_c) ? hit_way_c : '0;
         rsp_data  <= (req_valid && hit_c) ? word_c : '0;
      end
   end
endmodule

// File: rtl/vipt_cache_lookup_chk.sv
// Temporal checks on the lookup path, attached by bind.
module vipt_cache_lookup_chk #(
   parameter int unsigned WAY_W  = 4,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              tlb_valid,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic [WAY_W-1:0]  rsp_way,
   input logic [DATA_W-1:0] rsp_data
);
   a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r2_idle_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r5_no_translation_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !tlb_valid) |=> !rsp_hit);

   a_r9_miss_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_hit |-> (rsp_way == '0 && rsp_data == '0));

   a_r1_hit_only_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_valid);
endmodule

bind vipt_cache_lookup vipt_cache_lookup_chk #(
   .WAY_W (WAY_W),
   .DATA_W(DATA_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .tlb_valid(tlb_valid),
   .rsp_valid(rsp_valid),
   .rsp_hit  (rsp_hit),
   .rsp_way  (rsp_way),
   .rsp_data (rsp_data)
);

// File: tb/vipt_cache_lookup_tb.sv
module vipt_cache_lookup_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WAYS = 16;
   localparam int SETS = 64;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [23:0]  req_vaddr = '0;
   logic [11:0]  tlb_ppn = '0;
   logic         tlb_valid = 1'b0;
   logic         refill_valid = 1'b0;
   logic [5:0]   refill_index = '0;
   logic [11:0]  refill_ppn = '0;
   logic [511:0] refill_line = '0;
   logic         rsp_valid;
   logic         rsp_hit;
   logic [3:0]   rsp_way;
   logic [31:0]  rsp_data;

   always #(CLK_PERIOD / 2) clk = ~clk;

   vipt_cache_lookup dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_vaddr(req_vaddr),
      .tlb_ppn(tlb_ppn), .tlb_valid(tlb_valid),
      .refill_valid(refill_valid), .refill_index(refill_index),
      .refill_ppn(refill_ppn), .refill_line(refill_line),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_way(rsp_way), .rsp_data(rsp_data)
   );

   // Reference model
   bit           m_vld  [SETS][WAYS];
   bit [11:0]    m_tag  [SETS][WAYS];
   bit [511:0]   m_line [SETS][WAYS];
   bit [3:0]     m_ptr  [SETS];

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] mkva(input bit [11:0] vpn, input bit [5:0] set, input bit [3:0] word);
      return {vpn, set, word, 2'b00};
   endfunction

   function automatic bit [511:0] mkline();
      bit [511:0] l;
      for (int w = 0; w < 16; w++) l[w*32 +: 32] = $urandom;
      return l;
   endfunction

   // Expected result of a lookup against the current model contents
   task automatic expect_of(input logic [23:0] va, input bit [11:0] ppn, input bit tv,
                            output bit hit, output bit [3:0] way, output bit [31:0] data);
      int cnt;
      bit [5:0] set;
      set  = va[11:6];
      cnt  = 0;
      hit  = 0;
      way  = 0;
      data = 0;
      for (int w = 0; w < WAYS; w++) begin
         if (m_vld[set][w] && m_tag[set][w] == ppn) begin
            cnt++;
            way = 4'(w);
         end
      end
      if (tv && cnt == 1) begin
         hit  = 1;
         data = m_line[set][way][va[5:2]*32 +: 32];
      end else begin
         way = 0;
      end
   endtask

   task automatic model_refill(input bit [5:0] set, input bit [11:0] ppn, input bit [511:0] l);
      m_vld[set][m_ptr[set]]  = 1;
      m_tag[set][m_ptr[set]]  = ppn;
      m_line[set][m_ptr[set]] = l;
      m_ptr[set] = m_ptr[set] + 1;
   endtask

   task automatic do_refill(input bit [5:0] set, input bit [11:0] ppn, input bit [511:0] l);
      @(negedge clk);
      refill_valid = 1; refill_index = set; refill_ppn = ppn; refill_line = l;
      @(negedge clk);
      refill_valid = 0;
      model_refill(set, ppn, l);
   endtask

   task automatic do_lookup(input string req, input logic [23:0] va, input bit [11:0] ppn, input bit tv);
      bit eh; bit [3:0] ew; bit [31:0] ed;
      @(negedge clk);
      req_valid = 1; req_vaddr = va; tlb_ppn = ppn; tlb_valid = tv;
      expect_of(va, ppn, tv, eh, ew, ed);
      @(negedge clk);
      req_valid = 0;
      check({req, " R2 rsp_valid"}, 64'(rsp_valid), 64'd1);
      check({req, " hit"}, 64'(rsp_hit), 64'(eh));
      check({req, " way"}, 64'(rsp_way), 64'(ew));
      check({req, " data"}, 64'(rsp_data), 64'(ed));
   endtask

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R2 watchdog expired actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      bit [511:0] lines [WAYS + 1];
      bit [11:0]  pool [8];
      void'($urandom(32'd20240611));
      for (int s = 0; s < SETS; s++) m_ptr[s] = 0;

      // R1: reset state
      repeat (4) @(negedge clk);
      check("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
      check("R1 rsp_hit in reset", 64'(rsp_hit), 64'd0);
      rst_n = 1;
      @(negedge clk);
      check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
      do_lookup("R1 empty cache", mkva(12'h000, 6'd5, 4'd0), 12'h000, 1);
      @(negedge clk);
      check("R2 idle after lookup", 64'(rsp_valid), 64'd0);

      // R7: fill set 5 fully, then one more to wrap
      for (int w = 0; w <= WAYS; w++) begin
         lines[w] = mkline();
         do_refill(6'd5, 12'h100 + 12'(w), lines[w]);
      end
      // way 0 now holds ppn 0x110; ppn 0x100 was replaced
      do_lookup("R7 wrapped into way 0", mkva(12'h3A1, 6'd5, 4'd3), 12'h110, 1);
      check("R7 wrap way explicit", 64'(rsp_way), 64'd0);
      check("R6 word 3 of wrapped line", 64'(rsp_data), 64'(lines[WAYS][3*32 +: 32]));
      do_lookup("R7 replaced tag gone", mkva(12'h3A1, 6'd5, 4'd0), 12'h100, 1);
      for (int w = 1; w < WAYS; w++) begin
         do_lookup("R7 R6 way order", mkva(12'(w * 7), 6'd5, 4'(w)), 12'h100 + 12'(w), 1);
         check("R7 way index", 64'(rsp_way), 64'(w));
      end

      // R3: aliases differing in all virtual page bits
      do_lookup("R3 alias A", mkva(12'h000, 6'd5, 4'd15), 12'h105, 1);
      do_lookup("R3 alias B", mkva(12'hFFF, 6'd5, 4'd15), 12'h105, 1);
      check("R3 alias hits", 64'(rsp_hit), 64'd1);

      // R4: virtual page equal to stored tag, translation different
      do_lookup("R4 virtual bits not tag", mkva(12'h107, 6'd5, 4'd1), 12'h7FF, 1);
      check("R4 miss", 64'(rsp_hit), 64'd0);

      // R5: translation invalid
      do_lookup("R5 tlb invalid", mkva(12'h0, 6'd5, 4'd2), 12'h107, 0);
      check("R5 miss", 64'(rsp_hit), 64'd0);

      // R8: duplicate tag in set 9
      do_refill(6'd9, 12'h0AB, mkline());
      do_lookup("R8 single copy", mkva(12'h0, 6'd9, 4'd0), 12'h0AB, 1);
      check("R8 single copy hits", 64'(rsp_hit), 64'd1);
      do_refill(6'd9, 12'h0AB, mkline());
      do_lookup("R8 duplicate", mkva(12'h0, 6'd9, 4'd0), 12'h0AB, 1);
      check("R8 duplicate misses", 64'(rsp_hit), 64'd0);
      check("R9 duplicate data zero", 64'(rsp_data), 64'd0);

      // R10: lookup in the cycle of a refill to the same set
      begin
         bit eh; bit [3:0] ew; bit [31:0] ed;
         bit [511:0] l;
         l = mkline();
         @(negedge clk);
         refill_valid = 1; refill_index = 6'd12; refill_ppn = 12'h055; refill_line = l;
         req_valid = 1; req_vaddr = mkva(12'h0, 6'd12, 4'd4); tlb_ppn = 12'h055; tlb_valid = 1;
         expect_of(req_vaddr, 12'h055, 1, eh, ew, ed);
         @(negedge clk);
         refill_valid = 0; req_valid = 0;
         model_refill(6'd12, 12'h055, l);
         check("R10 same-cycle sees old", 64'(rsp_hit), 64'(eh));
         check("R10 old contents miss", 64'(rsp_hit), 64'd0);
         do_lookup("R10 next cycle sees new", mkva(12'h0, 6'd12, 4'd4), 12'h055, 1);
         check("R10 new line hit", 64'(rsp_hit), 64'd1);
         check("R6 word 4", 64'(rsp_data), 64'(l[4*32 +: 32]));
      end

      // Random traffic over a few sets and a small page pool
      for (int i = 0; i < 8; i++) pool[i] = 12'($urandom);
      for (int i = 0; i < 400; i++) begin
         bit [5:0] set;
         set = 6'd20 + 6'($urandom % 4);
         if ($urandom % 3 == 0) begin
            do_refill(set, pool[$urandom % 8], mkline());
         end else begin
            do_lookup("R3 R4 R6 R9 random", mkva(12'($urandom), set, 4'($urandom)),
                      pool[$urandom % 8], ($urandom % 8) != 0);
         end
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule